// File: doc/BRIEF.md
# Peripheral I/O Register Page with Read-Back Masks

This block is the byte-wide register page for a small set of peripheral controls that sit behind a CPU bus. The CPU drives an address, a data byte and a write strobe. Read data is combinational from the address. Every implemented register has a fixed OR pattern applied on read-back, so bits that are not implemented always read as 1. Any address outside the page reads as 0xFF.

Several writes have special handling. While the master audio-enable bit is clear, the sound registers take zero instead of the written byte. In the original-model variant, length writes still pass to the sound engine. The master sound-control register takes only its enable bit from the bus. The interrupt-flag register forces its three unused top bits high. Writes to the interrupt-flag or interrupt-enable register request a re-evaluation of pending interrupts. A write to the divider address stores nothing and only emits a clear pulse.

The block exports all stored values, a one-cycle write-event pulse for each register, and the data byte that belongs with that event. Downstream timer, video and sound units consume these outputs.

Top module: `iopg_regbank`

## Requirements
- R1: A read at BASE+i (page map: 0 irq flag, 1 irq enable, 2 timer control, 3 status, 4 display control, 5 bg palette, 6 sound master, 7 volume, 8 panning, 9 pulse-A length, 10 pulse-B length, 11 wave length, 12 noise length) returns the stored byte ORed with its mask. The masks are 0xE0 for offsets 0 and 1, 0xF8 for offset 2, 0x80 for offset 3, 0x70 for offset 6, 0xC0 for offsets 9 and 10, and 0x00 for all other offsets.
- R2: A read of any address outside offsets 0 to 12 returns 0xFF. This includes the divider address, which is BASE+13.
- R3: While bit 7 of the stored sound master byte is 0, a write to offsets 7 to 12 stores 0x00. Offsets 7 and 8 raise no write event in that case.
- R4: With ORIG_MODE=1 and audio disabled, a write to offsets 9 to 12 still raises that register's event. The event data is the bus byte ANDed with 0x3F for offsets 9 and 10, and the full bus byte for offsets 11 and 12. With ORIG_MODE=0 no event is raised.
- R5: A write to offset 6 stores bus bit 7 in bit 7 and keeps the stored bits 3:0. Bits 6:4 are stored as 0.
- R6: A write to offset 0 stores the bus byte with bits 7:5 set. A write to offset 0 or offset 1 pulses irq_reeval in the same cycle.
- R7: A write to the divider address pulses div_clr in the same cycle and changes no stored register.
- R8: Synchronous reset loads 0x01 at offset 0, 0x91 at offset 4, 0xFC at offset 5, 0xF1 at offset 6, 0x77 at offset 7, 0xF3 at offset 8, and 0x00 in all other registers.
- R9: wr_evt has at most one bit set. The bit for the addressed register is high in the same cycle as an accepted write. Outside the R4 case, evt_data equals the bus byte.
- R10: When bus_we is low, no stored value changes and no event, div_clr or irq_reeval pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read data |
| reg_flat | output | 13*8 | Stored register values, offset i at bits [8i+7:8i] |
| wr_evt | output | 13 | Per-register write-event pulses |
| evt_data | output | 8 | Data that accompanies the write event |
| div_clr | output | 1 | Divider clear pulse |
| irq_reeval | output | 1 | Interrupt re-evaluation pulse |

## Verification
Read data, write events, event data, div_clr and irq_reeval are combinational from the bus. They are due in the same cycle as the stimulus. Stored values change at the next rising edge and appear on reg_flat there. The bench drives the bus at the falling edge. It checks the combinational results 2 ns later, before the rising edge, using the model's state from before the write. It then checks every stored byte 1 ns after the rising edge, against the model updated with that write.

// File: rtl/iopg_pkg.sv
package iopg_pkg;
   localparam int NREG       = 13;
   localparam int IX_IFLAG   = 0;
   localparam int IX_IEN     = 1;
   localparam int IX_TCTL    = 2;
   localparam int IX_STAT    = 3;
   localparam int IX_DCTL    = 4;
   localparam int IX_BGPAL   = 5;
   localparam int IX_SNDMST  = 6;
   localparam int IX_SNDVOL  = 7;
   localparam int IX_SNDPAN  = 8;
   localparam int IX_PALEN   = 9;
   localparam int IX_PBLEN   = 10;
   localparam int IX_WVLEN   = 11;
   localparam int IX_NZLEN   = 12;

   function automatic logic is_sound(int i);
      return (i >= IX_SNDVOL) && (i <= IX_NZLEN);
   endfunction

   function automatic logic is_len(int i);
      return (i >= IX_PALEN) && (i <= IX_NZLEN);
   endfunction

   function automatic logic [7:0] rd_mask(int i, logic [7:0] plen_mask);
      case (i)
         IX_IFLAG, IX_IEN:   return 8'hE0;
         IX_TCTL:            return 8'hF8;
         IX_STAT:            return 8'h80;
         IX_SNDMST:          return 8'h70;
         IX_PALEN, IX_PBLEN: return ~plen_mask;
         default:            return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] rst_val(int i);
      case (i)
         IX_IFLAG:  return 8'h01;
         IX_DCTL:   return 8'h91;
         IX_BGPAL:  return 8'hFC;
         IX_SNDMST: return 8'hF1;
         IX_SNDVOL: return 8'h77;
         IX_SNDPAN: return 8'hF3;
         default:   return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/iopg_decode.sv
module iopg_decode #(
   parameter int AW   = 8,
   parameter int NREG = 13,
   parameter int BASE = 0
) (
   input  logic [AW-1:0]   addr,
   output logic [NREG-1:0] sel,
   output logic            div_hit
);
   localparam logic [AW-1:0] DIV_A = AW'(BASE + NREG);

   for (genvar g = 0; g < NREG; g++) begin : g_sel
      localparam logic [AW-1:0] MY_A = AW'(BASE + g);
      assign sel[g] = (addr == MY_A);
   end

   assign div_hit = (addr == DIV_A);
endmodule

// File: rtl/iopg_store.sv
module iopg_store
   import iopg_pkg::*;
#(
   parameter int ORIG_MODE = 1,
   parameter int PLEN_BITS = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [7:0]        wdata,
   input  logic [NREG-1:0]   sel,
   output logic [NREG*8-1:0] q_flat,
   output logic [NREG-1:0]   evt,
   output logic [7:0]        evt_data
);
   localparam logic [7:0] PLEN_MASK = 8'((1 << PLEN_BITS) - 1);

   logic aud_en;
   assign aud_en = q_flat[IX_SNDMST*8 + 7];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [7:0] r;
      logic [7:0] nxt;
      logic       ev;

      always_comb begin
         nxt = r;
         ev  = 1'b0;
         if (we && sel[g]) begin
            ev = 1'b1;
            if (g == IX_IFLAG) begin
               nxt = wdata | 8'hE0;
            end else if (g == IX_SNDMST) begin
               nxt = {wdata[7], 3'b000, r[3:0]};
            end else if (is_sound(g) && !aud_en) begin
               nxt = 8'h00;
               ev  = (ORIG_MODE != 0) && is_len(g);
            end else begin
               nxt = wdata;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (rst) r <= rst_val(g);
         else     r <= nxt;
      end

      assign q_flat[g*8 +: 8] = r;
      assign evt[g]           = ev;
   end

   if (ORIG_MODE != 0) begin : g_orig
      always_comb begin
         evt_data = wdata;
         if (!aud_en && (sel[IX_PALEN] || sel[IX_PBLEN]))
            evt_data = wdata & PLEN_MASK;
      end
   end else begin : g_plain
      assign evt_data = wdata;
   end
endmodule

// File: rtl/iopg_regbank.sv
module iopg_regbank
   import iopg_pkg::*;
#(
   parameter int AW        = 8,
   parameter int BASE      = 0,
   parameter int ORIG_MODE = 1,
   parameter int PLEN_BITS = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [AW-1:0]     bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   output logic [7:0]        bus_rdata,
   output logic [NREG*8-1:0] reg_flat,
   output logic [NREG-1:0]   wr_evt,
   output logic [7:0]        evt_data,
   output logic              div_clr,
   output logic              irq_reeval
);
   localparam logic [7:0] PLEN_MASK = 8'((1 << PLEN_BITS) - 1);

   if (PLEN_BITS < 1 || PLEN_BITS > 8) begin : g_bad_plen
      $error("PLEN_BITS must lie in 1..8");
   end
   if (BASE < 0 || BASE + NREG >= (1 << AW)) begin : g_bad_base
      $error("register page does not fit the address width");
   end

   logic [NREG-1:0] sel;
   logic            div_hit;

   iopg_decode #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_dec (
      .addr    (bus_addr),
      .sel     (sel),
      .div_hit (div_hit)
   );

   iopg_store #(.ORIG_MODE(ORIG_MODE), .PLEN_BITS(PLEN_BITS)) u_store (
      .clk      (clk),
      .rst      (rst),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .sel      (sel),
      .q_flat   (reg_flat),
      .evt      (wr_evt),
      .evt_data (evt_data)
   );

   always_comb begin
      bus_rdata = 8'hFF;
      for (int i = 0; i < NREG; i++) begin
         if (sel[i]) bus_rdata = reg_flat[i*8 +: 8] | rd_mask(i, PLEN_MASK);
      end
   end

   assign div_clr    = bus_we && div_hit;
   assign irq_reeval = bus_we && (sel[IX_IFLAG] || sel[IX_IEN]);
endmodule

// File: rtl/iopg_regbank_chk.sv
module iopg_regbank_chk
   import iopg_pkg::*;
#(
   parameter int AW   = 8,
   parameter int BASE = 0
) (
   input logic              clk,
   input logic              rst,
   input logic [AW-1:0]     bus_addr,
   input logic              bus_we,
   input logic [7:0]        bus_rdata,
   input logic [NREG*8-1:0] reg_flat,
   input logic [NREG-1:0]   wr_evt,
   input logic              div_clr,
   input logic              irq_reeval
);
   localparam logic [AW-1:0] A_LO  = AW'(BASE);
   localparam logic [AW-1:0] A_DIV = AW'(BASE + NREG);
   localparam logic [AW-1:0] A_MST = AW'(BASE + IX_SNDMST);
   localparam logic [AW-1:0] A_VOL = AW'(BASE + IX_SNDVOL);

   // R2
   unknown_ff_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_addr < A_LO || bus_addr >= A_DIV) |-> bus_rdata == 8'hFF);

   // R3
   snd_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_VOL && !reg_flat[IX_SNDMST*8 + 7])
      |=> reg_flat[IX_SNDVOL*8 +: 8] == 8'h00);

   // R5
   mst_nibble_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_MST)
      |=> reg_flat[IX_SNDMST*8 +: 4] == $past(reg_flat[IX_SNDMST*8 +: 4]));

   // R6
   irq_we_chk: assert property (@(posedge clk) disable iff (rst)
      irq_reeval |-> bus_we);

   // R7
   div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      div_clr |-> (bus_we && bus_addr == A_DIV));

   // R7
   div_nostore_chk: assert property (@(posedge clk) disable iff (rst)
      div_clr |=> $stable(reg_flat));

   // R9
   evt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_evt));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_we |=> $stable(reg_flat));
endmodule

bind iopg_regbank iopg_regbank_chk #(.AW(AW), .BASE(BASE)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .bus_rdata  (bus_rdata),
   .reg_flat   (reg_flat),
   .wr_evt     (wr_evt),
   .div_clr    (div_clr),
   .irq_reeval (irq_reeval)
);

// File: tb/iopg_regbank_tb.sv
module iopg_regbank_tb;
   localparam int N = 13;

   logic          clk = 1'b0;
   logic          rst;
   logic [7:0]    bus_addr;
   logic [7:0]    bus_wdata;
   logic          bus_we;
   logic [7:0]    bus_rdata;
   logic [N*8-1:0] reg_flat;
   logic [N-1:0]  wr_evt;
   logic [7:0]    evt_data;
   logic          div_clr;
   logic          irq_reeval;

   int checks = 0;
   int errors = 0;
   logic [7:0] m [N];

   always #5 clk = ~clk;

   iopg_regbank u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .reg_flat(reg_flat),
      .wr_evt(wr_evt), .evt_data(evt_data), .div_clr(div_clr),
      .irq_reeval(irq_reeval)
   );

   function automatic logic [7:0] f_mask(int i);
      case (i)
         0, 1:    return 8'hE0;
         2:       return 8'hF8;
         3:       return 8'h80;
         6:       return 8'h70;
         9, 10:   return 8'hC0;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] f_rst(int i);
      case (i)
         0: return 8'h01;  4: return 8'h91;  5: return 8'hFC;
         6: return 8'hF1;  7: return 8'h77;  8: return 8'hF3;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      for (int i = 0; i < N; i++)
         chk(reg_flat[i*8 +: 8] === m[i], req, 32'(reg_flat[i*8 +: 8]), 32'(m[i]));
   endtask

   task automatic step(input bit we, input int a, input logic [7:0] d);
      logic [N-1:0] e_evt;
      logic [7:0]   e_dat, e_rd, nv;
      bit aud, e_div, e_irq;
      string rq;
      @(negedge clk);
      bus_we = we; bus_addr = 8'(a); bus_wdata = d;
      aud   = m[6][7];
      e_evt = '0; e_dat = d; nv = d;
      e_div = we && (a == 13);
      e_irq = we && (a == 0 || a == 1);
      e_rd  = (a < N) ? (m[a] | f_mask(a)) : 8'hFF;
      rq = "R9";
      if (we && a < N) begin
         if (a >= 7 && !aud) begin
            nv = 8'h00;
            if (a >= 9) begin
               e_evt[a] = 1'b1; rq = "R4";
               if (a <= 10) e_dat = d & 8'h3F;
            end else rq = "R3";
         end else begin
            e_evt[a] = 1'b1;
            if (a == 0) begin nv = d | 8'hE0; rq = "R6"; end
            if (a == 6) begin nv = {d[7], 3'b000, m[6][3:0]}; rq = "R5"; end
         end
      end
      if (!we) rq = "R10";
      #2;
      chk(wr_evt === e_evt, rq, 32'(wr_evt), 32'(e_evt));
      if (e_evt != '0) chk(evt_data === e_dat, rq, 32'(evt_data), 32'(e_dat));
      chk(div_clr === e_div, "R7", 32'(div_clr), 32'(e_div));
      chk(irq_reeval === e_irq, "R6", 32'(irq_reeval), 32'(e_irq));
      chk(bus_rdata === e_rd, (a < N) ? "R1" : "R2", 32'(bus_rdata), 32'(e_rd));
      @(posedge clk);
      #1;
      if (we && a < N) m[a] = nv;
      check_regs(e_div ? "R7" : rq);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D5E_0A07));
      rst = 1'b1; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
      for (int i = 0; i < N; i++) m[i] = f_rst(i);
      repeat (2) @(posedge clk);
      #1 check_regs("R8");
      @(negedge clk) rst = 1'b0;
      for (int i = 0; i < 16; i++) step(1'b0, i, 8'h00);  // R8 read-back, R1, R2
      step(1'b0, 0, 8'h00);          // R10 strobe low
      step(1'b1, 0, 8'h00);          // R6 flag write reads 0xE0
      step(1'b1, 1, 8'h5A);          // R6 enable write
      step(1'b1, 13, 8'hAA);         // R7 divider
      step(1'b1, 6, 8'h00);          // R5 audio off, nibble kept
      step(1'b1, 7, 8'h55);          // R3 zeroed
      step(1'b1, 8, 8'h12);          // R3
      step(1'b1, 9, 8'hFF);          // R4 masked forward
      step(1'b1, 10, 8'hC7);         // R4
      step(1'b1, 11, 8'hAB);         // R4 full byte
      step(1'b1, 12, 8'h3C);         // R4
      step(1'b1, 6, 8'hFF);          // R5 audio on
      step(1'b1, 7, 8'h55);          // R9 stored
      step(1'b1, 9, 8'hFF);          // R1 mask 0xC0
      step(1'b1, 2, 8'h07);          // R1 timer mask
      step(1'b1, 3, 8'h7F);          // R1 status mask
      step(1'b1, 200, 8'h99);        // R2 far address
      for (int k = 0; k < 1500; k++) begin
         int a;
         bit we;
         we = ($urandom % 4) != 0;
         a  = ($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 16);
         step(we, a, 8'($urandom));
      end
      @(negedge clk) bus_we = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule